// File: doc/BRIEF.md
# Ethernet Transmit Frame FIFO

This block gathers one outgoing Ethernet frame from 32-bit data writes into a byte-addressed buffer of `BYTES` bytes (2048 by default). Bytes go into the buffer in the order they are written, least significant byte of each word first. The first word written into an empty buffer is a header. Its low 16 bits give the payload length and its upper 16 bits are the first two bytes of the frame. The length is checked when the header arrives, and it then decides three things: when the frame counts as complete, how many bytes are sent, and whether zero padding is added.

A send starts in one of two ways. An automatic send starts after a data write when two conditions both hold: the fill threshold has been reached and the frame is complete. A manual send starts when the transmit-request pulse arrives, whatever the FIFO holds. The frame leaves as a byte stream with valid/ready handshakes. `m_valid` stays high until every byte has been accepted. `m_data` and `m_last` hold still while the sink keeps `m_ready` low. The source never withdraws a byte it has offered, and there is no limit on how long the sink may stall. While a send is in progress, `busy` is high and any data write or transmit request is dropped.

A header with an oversize length is refused and sets a sticky error flag. Acknowledging that flag also empties the FIFO. When a frame completes, the FIFO is emptied and a one-cycle transmit-empty pulse follows.

Top module: `tx_frame_fifo`

## Requirements
- R1: When the byte count is 0, a write whose low 16 bits exceed `BYTES`-16 (2032) stores nothing, and `tx_err` goes high on the next cycle. `tx_err` stays high until it is acknowledged.
- R2: An accepted write stores its four bytes at buffer positions count..count+3, least significant byte first. The write is dropped when fewer than 4 bytes of room remain. The header word occupies buffer bytes 0 to 3.
- R3: The frame is complete when the byte count is at least the header length plus 16 (with `crc_auto` = 1) or plus 20 (with `crc_auto` = 0). The required count is capped at `BYTES`.
- R4: The threshold is met when the threshold value is not all ones and the byte count is at least 32*threshold+4. The threshold resets to all ones (63), which disables automatic sends. It is loaded from `thr_wdata` when `thr_we` is high.
- R5: On every data write that stores or is dropped for lack of room, if the threshold is met and the frame is complete after that write, `m_valid` rises on the next cycle.
- R6: A `tx_req` pulse while idle starts a send on the next cycle, whatever the byte count.
- R7: The stream carries buffer bytes from position 2 onward. The byte count is the length plus 14, raised to 60 when `pad_en` = 1 and it is below 60, and capped at `BYTES`-2. A byte at or beyond position length+16, or at or beyond the stored count, is sent as zero. `m_last` marks the final byte.
- R8: While `m_valid` = 1 and `m_ready` = 0, `m_valid`, `m_data` and `m_last` hold their values on the next cycle.
- R9: Once the last byte is accepted, `m_valid` drops and the byte count returns to 0 (the next write is a header). `tx_empty` is high for exactly one cycle after that handshake.
- R10: An `err_ack` pulse clears `tx_err`. When no send is active, it also resets the byte count to 0.
- R11: `busy` is high for the whole send. Data writes and `tx_req` are ignored while it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_valid | input | 1 | Data word write strobe |
| wr_data | input | 32 | Data word; the first word into an empty FIFO is the length header |
| thr_we | input | 1 | Load strobe for the fill threshold |
| thr_wdata | input | THR_W | New fill threshold; all ones disables automatic sends |
| crc_auto | input | 1 | 1: the frame needs no CRC bytes from the writer (+16 rule); 0: +20 rule |
| pad_en | input | 1 | Pad short frames with zeros up to 60 bytes |
| tx_req | input | 1 | Manual send request pulse |
| err_ack | input | 1 | Clears the error flag and empties an idle FIFO |
| busy | output | 1 | A send is in progress |
| tx_err | output | 1 | Sticky oversize-header error flag |
| tx_empty | output | 1 | One-cycle pulse after a send completes |
| m_valid | output | 1 | Output byte valid |
| m_data | output | 8 | Output byte |
| m_last | output | 1 | Final byte of the frame |
| m_ready | input | 1 | Sink accepts the byte |

## Verification
A wrong byte count shows first as a send starting too early or too late. The stream then has the wrong length or exposes stale bytes in place of zero padding, and both show at the ports on the very next cycle or within the frame. A wrong stored length or send position corrupts `m_data` or moves `m_last` inside the same frame. A lost flush shows on the next header write: it is either taken as data or raises no error. The reference model is compared every cycle, so each of these shows up within a cycle or two of the first wrong output.

// File: rtl/tx_fifo_pkg.sv
package tx_fifo_pkg;
  // bytes of length header ahead of the frame in the buffer
  localparam int unsigned LEAD_BYTES   = 2;
  localparam int unsigned MAC_HDR      = 14;
  localparam int unsigned SHORTEST     = 60;
  localparam int unsigned NEED_CRC_HW  = 16;
  localparam int unsigned NEED_CRC_SW  = 20;

  function automatic logic [31:0] umin(input logic [31:0] a, input logic [31:0] b);
    return (a < b) ? a : b;
  endfunction
endpackage

// File: rtl/tx_frame_store.sv
module tx_frame_store #(
  parameter int unsigned BYTES = 2048,
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [31:0]      wr_data,
  input  logic             flush,
  input  logic [CNT_W-1:0] rd_idx,
  output logic [CNT_W-1:0] count,
  output logic             room,
  output logic [7:0]       rd_byte
);
  localparam int unsigned WORDS = BYTES / 4;
  localparam int unsigned AW    = $clog2(WORDS);

  logic [31:0]      mem [WORDS];
  logic [CNT_W-1:0] count_q;
  logic [31:0]      rd_word;
  logic             store;

  assign room  = (32'(count_q) + 32'd4) <= BYTES;
  assign store = wr_en && room;
  assign count = count_q;

  always_ff @(posedge clk) begin
    if (store) mem[count_q[AW+1:2]] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      count_q <= '0;
    else if (flush)  count_q <= '0;
    else if (store)  count_q <= count_q + CNT_W'(4);
  end

  assign rd_word = mem[rd_idx[AW+1:2]];
  always_comb begin
    rd_byte = 8'h00;
    for (int k = 0; k < 4; k++) begin
      if (rd_idx[1:0] == 2'(k)) rd_byte = rd_word[8*k +: 8];
    end
  end
endmodule

// File: rtl/tx_frame_rules.sv
module tx_frame_rules
  import tx_fifo_pkg::*;
#(
  parameter int unsigned BYTES = 2048,
  parameter int unsigned CNT_W = 12,
  parameter int unsigned THR_W = 6
) (
  input  logic [CNT_W-1:0] cnt_after,
  input  logic [15:0]      hdr_len,
  input  logic [THR_W-1:0] thr,
  input  logic             crc_auto,
  input  logic             pad_en,
  output logic             complete,
  output logic             thr_met,
  output logic [CNT_W-1:0] last_pos
);
  logic [31:0] need;
  logic [31:0] flen;

  always_comb begin
    need     = umin(32'(hdr_len) + (crc_auto ? NEED_CRC_HW : NEED_CRC_SW), BYTES);
    complete = 32'(cnt_after) >= need;
    thr_met  = (thr != '1) && (32'(cnt_after) >= (32'(thr) * 32'd32 + 32'd4));
    flen     = 32'(hdr_len) + MAC_HDR;
    if (pad_en && flen < SHORTEST) flen = SHORTEST;
    flen     = umin(flen, BYTES - LEAD_BYTES);
    last_pos = CNT_W'(flen + LEAD_BYTES - 1);
  end
endmodule

// File: rtl/tx_frame_sender.sv
module tx_frame_sender
  import tx_fifo_pkg::*;
#(
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] last_in,
  input  logic             m_ready,
  output logic             sending,
  output logic [CNT_W-1:0] pos,
  output logic             at_last,
  output logic             done
);
  logic [CNT_W-1:0] last_q;

  assign at_last = sending && (pos == last_q);
  assign done    = at_last && m_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sending <= 1'b0;
      pos     <= '0;
      last_q  <= '0;
    end else if (start) begin
      sending <= 1'b1;
      pos     <= CNT_W'(LEAD_BYTES);
      last_q  <= last_in;
    end else if (sending && m_ready) begin
      if (at_last) sending <= 1'b0;
      else         pos     <= pos + CNT_W'(1);
    end
  end
endmodule

// File: rtl/tx_frame_fifo.sv
module tx_frame_fifo
  import tx_fifo_pkg::*;
#(
  parameter int unsigned BYTES = 2048,
  parameter int unsigned THR_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_valid,
  input  logic [31:0]      wr_data,
  input  logic             thr_we,
  input  logic [THR_W-1:0] thr_wdata,
  input  logic             crc_auto,
  input  logic             pad_en,
  input  logic             tx_req,
  input  logic             err_ack,
  output logic             busy,
  output logic             tx_err,
  output logic             tx_empty,
  output logic             m_valid,
  output logic [7:0]       m_data,
  output logic             m_last,
  input  logic             m_ready
);
  localparam int unsigned CNT_W   = $clog2(BYTES) + 1;
  localparam int unsigned MAX_LEN = BYTES - NEED_CRC_HW;

  logic [CNT_W-1:0] count, cnt_after, pos, last_pos;
  logic [15:0]      len_q, hdr_len;
  logic [THR_W-1:0] thr_q;
  logic             room, sending, at_last, done;
  logic             wr_ok, hdr_bad, store_en, complete, thr_met, start, flush;
  logic [7:0]       raw_byte;

  assign wr_ok     = wr_valid && !sending;
  assign hdr_bad   = wr_ok && (count == '0) && (32'(wr_data[15:0]) > MAX_LEN);
  assign store_en  = wr_ok && !hdr_bad;
  assign cnt_after = (store_en && room) ? count + CNT_W'(4) : count;
  assign hdr_len   = (store_en && count == '0) ? wr_data[15:0] : len_q;
  assign start     = (store_en && complete && thr_met) || (tx_req && !sending);
  assign flush     = done || (err_ack && !sending);

  tx_frame_store #(.BYTES(BYTES), .CNT_W(CNT_W)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(store_en), .wr_data(wr_data), .flush(flush),
    .rd_idx(pos), .count(count), .room(room), .rd_byte(raw_byte)
  );

  tx_frame_rules #(.BYTES(BYTES), .CNT_W(CNT_W), .THR_W(THR_W)) u_rules (
    .cnt_after(cnt_after), .hdr_len(hdr_len), .thr(thr_q), .crc_auto(crc_auto),
    .pad_en(pad_en), .complete(complete), .thr_met(thr_met), .last_pos(last_pos)
  );

  tx_frame_sender #(.CNT_W(CNT_W)) u_send (
    .clk(clk), .rst_n(rst_n), .start(start), .last_in(last_pos), .m_ready(m_ready),
    .sending(sending), .pos(pos), .at_last(at_last), .done(done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q    <= '0;
      thr_q    <= '1;
      tx_err   <= 1'b0;
      tx_empty <= 1'b0;
    end else begin
      if (store_en && count == '0) len_q <= wr_data[15:0];
      if (thr_we) thr_q <= thr_wdata;
      if (hdr_bad)      tx_err <= 1'b1;
      else if (err_ack) tx_err <= 1'b0;
      tx_empty <= done;
    end
  end

  // bytes past the written data or inside the pad region go out as zero
  assign m_data  = ((32'(pos) < 32'(len_q) + NEED_CRC_HW) && (pos < count)) ? raw_byte : 8'h00;
  assign m_valid = sending;
  assign m_last  = at_last;
  assign busy    = sending;
endmodule

// File: rtl/tx_frame_fifo_chk.sv
module tx_frame_fifo_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_valid,
  input logic       tx_req,
  input logic       err_ack,
  input logic       busy,
  input logic       tx_err,
  input logic       tx_empty,
  input logic       m_valid,
  input logic [7:0] m_data,
  input logic       m_last,
  input logic       m_ready
);
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !m_ready |=> m_valid && $stable(m_data) && $stable(m_last));

  assert_finish_R9: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && m_ready && m_last |=> !m_valid && tx_empty);

  assert_empty_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty |-> $past(m_valid && m_ready && m_last));

  assert_manual_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req && !busy |=> m_valid);

  assert_ack_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    err_ack && !wr_valid |=> !tx_err);

  assert_err_cause_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_err) |-> $past(wr_valid && !busy));

  assert_busy_blocks_R11: assert property (@(posedge clk) disable iff (!rst_n)
    busy && wr_valid |=> !$rose(tx_err));
endmodule

bind tx_frame_fifo tx_frame_fifo_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .tx_req(tx_req), .err_ack(err_ack),
  .busy(busy), .tx_err(tx_err), .tx_empty(tx_empty), .m_valid(m_valid),
  .m_data(m_data), .m_last(m_last), .m_ready(m_ready)
);

// File: tb/tx_frame_fifo_tb.sv
module tx_frame_fifo_tb;
  localparam int CLK_PERIOD = 10;
  localparam int BYTES = 2048;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_valid = 1'b0;
  logic [31:0] wr_data = '0;
  logic thr_we = 1'b0;
  logic [5:0] thr_wdata = '0;
  logic crc_auto = 1'b1;
  logic pad_en = 1'b0;
  logic tx_req = 1'b0;
  logic err_ack = 1'b0;
  logic m_ready = 1'b1;
  logic busy, tx_err, tx_empty, m_valid, m_last;
  logic [7:0] m_data;
  bit bp = 1'b0;

  int checks = 0;
  int fails = 0;
  int cyc = 0;

  // reference model state
  int m_buf [BYTES];
  int m_cnt = 0, m_len = 0, m_thr = 63, m_pos = 0, m_lastp = 0;
  bit m_send = 0, m_err = 0, m_empty = 0;

  tx_frame_fifo u_dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
    .thr_we(thr_we), .thr_wdata(thr_wdata), .crc_auto(crc_auto), .pad_en(pad_en),
    .tx_req(tx_req), .err_ack(err_ack), .busy(busy), .tx_err(tx_err),
    .tx_empty(tx_empty), .m_valid(m_valid), .m_data(m_data), .m_last(m_last),
    .m_ready(m_ready)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  // behavioural model, advanced on each rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_len = 0; m_thr = 63; m_send = 0; m_err = 0; m_empty = 0;
      m_pos = 0; m_lastp = 0;
    end else begin
      bit was_send, fin, wok, bad, st, go;
      int need, flen;
      was_send = m_send;
      fin = m_send && m_ready && (m_pos == m_lastp);
      wok = wr_valid && !was_send;
      bad = wok && m_cnt == 0 && int'(wr_data[15:0]) > BYTES - 16;
      st  = wok && !bad;
      if (st && m_cnt + 4 <= BYTES) begin
        for (int k = 0; k < 4; k++) m_buf[m_cnt + k] = int'(wr_data[8*k +: 8]);
        if (m_cnt == 0) m_len = int'(wr_data[15:0]);
        m_cnt += 4;
      end
      need = m_len + (crc_auto ? 16 : 20);
      if (need > BYTES) need = BYTES;
      go = (st && m_cnt >= need && m_thr != 63 && m_cnt >= 32 * m_thr + 4)
           || (tx_req && !was_send);
      if (was_send && m_ready) begin
        if (fin) begin m_send = 0; m_cnt = 0; end
        else m_pos++;
      end
      if (err_ack && !was_send) m_cnt = 0;
      if (go) begin
        flen = m_len + 14;
        if (pad_en && flen < 60) flen = 60;
        if (flen > BYTES - 2) flen = BYTES - 2;
        m_lastp = flen + 1;
        m_pos = 2;
        m_send = 1;
      end
      if (bad) m_err = 1;
      else if (err_ack) m_err = 0;
      m_empty = fin;
      if (thr_we) m_thr = int'(thr_wdata);
    end
  end

  // compare on every falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      int exp_d;
      bit exp_l;
      exp_l = m_send && (m_pos == m_lastp);
      chk(m_valid === m_send, "R3 R4 R5 R6 R9 m_valid", int'(m_valid), int'(m_send));
      chk(busy === m_send, "R11 busy", int'(busy), int'(m_send));
      chk(tx_err === m_err, "R1 R10 tx_err", int'(tx_err), int'(m_err));
      chk(tx_empty === m_empty, "R9 tx_empty", int'(tx_empty), int'(m_empty));
      if (m_send) begin
        exp_d = (m_pos < m_len + 16 && m_pos < m_cnt) ? m_buf[m_pos] : 0;
        chk(m_data === 8'(exp_d), "R2 R7 m_data", int'(m_data), exp_d);
        chk(m_last === exp_l, "R7 R8 m_last", int'(m_last), int'(exp_l));
      end
    end
  end

  always @(negedge clk) begin
    #1;
    m_ready = bp ? 1'($urandom_range(0, 1)) : 1'b1;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog R9 actual=%0d expected=%0d", cyc, 150000);
      summary();
      $finish;
    end
  end

  // stimulus helpers: each starts just after a falling edge and uses one cycle
  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic put(input logic [31:0] w);
    wr_valid = 1'b1; wr_data = w;
    step();
    wr_valid = 1'b0;
  endtask

  task automatic req();
    tx_req = 1'b1; step(); tx_req = 1'b0;
  endtask

  task automatic ack();
    err_ack = 1'b1; step(); err_ack = 1'b0;
  endtask

  task automatic set_thr(input int t);
    thr_we = 1'b1; thr_wdata = 6'(t); step(); thr_we = 1'b0;
  endtask

  task automatic frame(input int len, input int nwords, input int seed);
    put({16'hC0DE ^ 16'(seed), 16'(len)});
    for (int i = 1; i < nwords; i++) put(32'(seed * 7919 + i) * 32'h9E3779B1);
  endtask

  task automatic drain();
    int guard = 0;
    while (m_send && guard < 20000) begin step(); guard++; end
    step(); step();
  endtask

  initial begin
    for (int i = 0; i < BYTES; i++) m_buf[i] = 0;
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    step();
    // reset state
    chk(busy === 1'b0 && m_valid === 1'b0, "R11 reset idle", int'(busy), 0);
    chk(tx_err === 1'b0 && tx_empty === 1'b0, "R1 R9 reset flags", int'(tx_err), 0);

    // R4: threshold disabled at reset, no auto send; R6 manual send; R7 padding
    crc_auto = 1'b1; pad_en = 1'b1;
    frame(20, 10, 1);
    repeat (4) step();
    chk(m_valid === 1'b0, "R4 no auto send at reset threshold", int'(m_valid), 0);
    req();
    drain();

    // R3 R5: threshold 0, CRC by hardware, 17 words complete a 50-byte payload
    pad_en = 1'b0;
    set_thr(0);
    frame(50, 16, 2);
    chk(m_valid === 1'b0, "R3 not complete after 16 words", int'(m_valid), 0);
    put(32'h1234_5678);
    chk(m_valid === 1'b1, "R5 auto send after completing word", int'(m_valid), 1);
    drain();

    // R6: manual send on an empty FIFO gives zeros with the last length
    req();
    drain();

    // R3: writer supplies CRC, needs 20 extra bytes
    crc_auto = 1'b0;
    frame(50, 17, 3);
    chk(m_valid === 1'b0, "R3 crc off not complete at 68 bytes", int'(m_valid), 0);
    put(32'hCAFE_F00D);
    drain();

    // R4: threshold 2 needs 68 bytes although frame completes at 28
    crc_auto = 1'b1;
    set_thr(2);
    frame(10, 16, 4);
    chk(m_valid === 1'b0, "R4 threshold not yet met", int'(m_valid), 0);
    put(32'h0BAD_BEEF);
    drain();

    // R1 R10: oversize header, acknowledge, flush of a partial frame
    put(32'h0000_07F1);
    chk(tx_err === 1'b1, "R1 oversize header flagged", int'(tx_err), 1);
    ack();
    frame(100, 3, 5);
    ack();
    put(32'h0000_07F8);
    chk(tx_err === 1'b1, "R10 flush made next word a header", int'(tx_err), 1);
    ack();
    frame(2032, 1, 6);
    ack();

    // R8 R11: back-pressure, padding, writes and requests ignored while busy
    bp = 1'b1; pad_en = 1'b1;
    set_thr(0);
    frame(30, 12, 7);
    put(32'h0000_07FF);
    put(32'h1111_2222);
    req();
    chk(tx_err === 1'b0, "R11 busy write not seen as header", int'(tx_err), 0);
    drain();

    // R2 R3: fill the whole buffer, one extra write dropped, capped length
    bp = 1'b0; crc_auto = 1'b0;
    set_thr(63);
    frame(2032, 513, 8);
    chk(m_valid === 1'b0, "R2 full buffer no auto send", int'(m_valid), 0);
    set_thr(0);
    put(32'h5555_AAAA);
    chk(m_valid === 1'b1, "R5 dropped write still triggers send", int'(m_valid), 1);
    drain();

    repeat (5) step();
    summary();
    $finish;
  end
endmodule